// File: doc/BRIEF.md
# DES Round Subkey Generator (Bidirectional)

This block supplies the 48-bit round subkey to a folded DES round engine, one subkey per round, in either the forward order used to encrypt or the reversed order used to decrypt. A 64-bit key is captured on a load strobe. Each advance strobe then steps the schedule by one round. The subkey is held in registers, so the round engine sees the new key in the cycle after each strobe. This matches a round engine whose round register sits behind its S-box lookup.

Internally, the key is reduced by the fixed first permuted choice into two 28-bit halves. Each half has its own register with a load multiplexer and a rotator. In encrypt mode the rotator turns left and in decrypt mode it turns right. The amount is one or two places, taken from the standard round schedule. The second permuted choice compresses the two halves into the subkey. Both permutations are wiring only.

The decrypt sequence needs no rotation before its first subkey, so that subkey comes out immediately. The full schedule rotates each half by 28 places in total, so the sequence is cyclic. Further advances repeat the 16 subkeys without a reload, which suits triple-DES passes that reuse one key.

Top module: `deskey_sched`

## Requirements
- R1: While no key has been loaded since reset, `subKey` is all zeros, whatever `advance` does.
- R2: In the cycle after `loadKey` is sampled high with `decryptMode` low, `subKey` equals round subkey K1 of `keyIn`. Loading the same key in the same mode again gives the same subkey.
- R3: In encrypt mode, each sampled `advance` moves `subKey` to the next round, K1 through K16. Between rounds the halves rotate left by one place before rounds 1, 2, 9 and 16, and by two places before every other round.
- R4: In the cycle after `loadKey` is sampled high with `decryptMode` high, `subKey` equals K16, with no rotation applied to the halves.
- R5: In decrypt mode, each sampled `advance` moves `subKey` one round down the order K16, K15, ... K1, using right rotations that mirror the encrypt schedule.
- R6: In a cycle where neither `loadKey` nor `advance` is high, `subKey` does not change in the next cycle.
- R7: After the last subkey of a sequence, a further `advance` returns to the first subkey of that sequence (K1 when encrypting, K16 when decrypting).
- R8: When `loadKey` and `advance` are high in the same cycle, the load takes effect and the advance is ignored.
- R9: `decryptMode` is sampled only together with `loadKey`. Changing it at any other time has no effect on the subkeys that follow.
- R10: The eight parity bits of the key (`keyIn` bits 56, 48, 40, 32, 24, 16, 8 and 0) have no effect on any subkey.
- R11: Bit numbering is big-endian. `keyIn[63]` is key bit 1 and `subKey[47]` is subkey bit 1 of the standard tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| keyIn | input | 64 | Key, bit 63 is key bit 1 |
| loadKey | input | 1 | Capture `keyIn` and `decryptMode`, start at the first round |
| advance | input | 1 | Step to the next round subkey |
| decryptMode | input | 1 | 0 selects forward order, 1 selects reversed order (sampled on load) |
| subKey | output | 48 | Current round subkey, bit 47 is subkey bit 1 |

## Verification
The bench builds the block with its default widths: 64-bit key, 28-bit halves, 48-bit subkey and a 16-round schedule. With these widths, a 4-bit round counter wraps exactly where the schedule completes its 28-place turn. This brings the wrap-around of both directions within reach of the cycle-by-cycle comparison. The same widths allow anchoring against published subkeys of a well-known key and against the weak keys whose subkeys are all zeros or all ones.

// File: rtl/deskey_pkg.sv
package deskey_pkg;

  localparam int KEY_W     = 64;
  localparam int HALF_W    = 28;
  localparam int SUB_W     = 48;
  localparam int ROUNDS    = 16;
  localparam int RND_W     = $clog2(ROUNDS);
  localparam int KEY_IDX_W = $clog2(KEY_W);
  localparam int CD_IDX_W  = $clog2(2 * HALF_W);

  // Rounds (0-based) whose rotation is a single place; all others use two.
  localparam logic [ROUNDS-1:0] SINGLE_MASK = 16'h8103;

  // First permuted choice: 1-based key bit positions, first half then second.
  localparam int unsigned PC1_TAB [2*HALF_W] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
  };

  // Second permuted choice: 1-based positions within the 56-bit half pair.
  localparam int unsigned PC2_TAB [SUB_W] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
  };

  // Strobes from the control to the half registers.
  typedef struct packed {
    logic load;      // take the freshly permuted key half
    logic update;    // write the register this cycle
    logic rotNone;   // pass through without rotating
    logic rotRight;  // direction: 1 = right, 0 = left
    logic rotTwo;    // amount: 1 = two places, 0 = one place
  } ksStrobe_t;

endpackage

// File: rtl/ks_ctrl.sv
module ks_ctrl
  import deskey_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadKey,
  input  logic      advance,
  input  logic      decryptMode,
  output ksStrobe_t strb
);

  logic [RND_W-1:0] roundIdx;
  logic [RND_W-1:0] nextIdx;
  logic [RND_W-1:0] mirrorIdx;
  logic             decLatched;

  always_comb begin
    nextIdx   = roundIdx + 1'b1;
    mirrorIdx = RND_W'(ROUNDS - 1) - roundIdx;
    strb          = '0;
    strb.load     = loadKey;
    strb.update   = loadKey | advance;
    if (loadKey) begin
      // decrypt starts at the last subkey, which needs no rotation
      strb.rotNone  = decryptMode;
      strb.rotRight = 1'b0;
      strb.rotTwo   = ~SINGLE_MASK[0];
    end else if (advance) begin
      if (decLatched) begin
        // undo the rotation that produced the current subkey
        strb.rotRight = 1'b1;
        strb.rotTwo   = ~SINGLE_MASK[mirrorIdx];
      end else begin
        strb.rotRight = 1'b0;
        strb.rotTwo   = ~SINGLE_MASK[nextIdx];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      roundIdx   <= '0;
      decLatched <= 1'b0;
    end else if (loadKey) begin
      roundIdx   <= '0;
      decLatched <= decryptMode;
    end else if (advance) begin
      roundIdx   <= nextIdx;
    end
  end

endmodule

// File: rtl/ks_half_rot.sv
module ks_half_rot
  import deskey_pkg::*;
#(
  parameter int W = HALF_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  ksStrobe_t    strb,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] cur
);

  logic [W-1:0] src;
  logic [W-1:0] rotated;

  always_comb begin
    src = strb.load ? loadVal : cur;
    if (strb.rotNone)
      rotated = src;
    else if (strb.rotRight)
      rotated = strb.rotTwo ? {src[1:0], src[W-1:2]} : {src[0], src[W-1:1]};
    else
      rotated = strb.rotTwo ? {src[W-3:0], src[W-1:W-2]} : {src[W-2:0], src[W-1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cur <= '0;
    else if (strb.update) cur <= rotated;
  end

endmodule

// File: rtl/ks_datapath.sv
module ks_datapath
  import deskey_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ksStrobe_t        strb,
  input  logic [KEY_W-1:0] keyIn,
  output logic [SUB_W-1:0] subKey
);

  logic [HALF_W-1:0]   halfLoad [2];
  logic [HALF_W-1:0]   halfCur  [2];
  logic [2*HALF_W-1:0] pairCat;

  // First permuted choice: wiring only, MSB of each half is its first bit.
  always_comb begin
    for (int i = 0; i < HALF_W; i++) begin
      halfLoad[0][i] = keyIn[KEY_IDX_W'(KEY_W - int'(PC1_TAB[HALF_W-1-i]))];
      halfLoad[1][i] = keyIn[KEY_IDX_W'(KEY_W - int'(PC1_TAB[2*HALF_W-1-i]))];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : gHalf
    ks_half_rot #(.W(HALF_W)) uRot (
      .clk     (clk),
      .rstN    (rstN),
      .strb    (strb),
      .loadVal (halfLoad[g]),
      .cur     (halfCur[g])
    );
  end

  // Second permuted choice: wiring only.
  always_comb begin
    pairCat = {halfCur[0], halfCur[1]};
    for (int j = 0; j < SUB_W; j++)
      subKey[j] = pairCat[CD_IDX_W'(2*HALF_W - int'(PC2_TAB[SUB_W-1-j]))];
  end

endmodule

// File: rtl/deskey_sched.sv
module deskey_sched
  import deskey_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [KEY_W-1:0] keyIn,
  input  logic             loadKey,
  input  logic             advance,
  input  logic             decryptMode,
  output logic [SUB_W-1:0] subKey
);

  ksStrobe_t strb;

  ks_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .loadKey     (loadKey),
    .advance     (advance),
    .decryptMode (decryptMode),
    .strb        (strb)
  );

  ks_datapath uPath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .keyIn  (keyIn),
    .subKey (subKey)
  );

endmodule

// File: rtl/deskey_sched_chk.sv
module deskey_sched_chk
  import deskey_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [KEY_W-1:0] keyIn,
  input logic             loadKey,
  input logic             advance,
  input logic             decryptMode,
  input logic [SUB_W-1:0] subKey
);

  logic             loadSeen;
  logic             captureNext;
  logic [SUB_W-1:0] firstKey;
  logic [RND_W-1:0] advCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadSeen    <= 1'b0;
      captureNext <= 1'b0;
      firstKey    <= '0;
      advCnt      <= '0;
    end else begin
      captureNext <= loadKey;
      if (captureNext) firstKey <= subKey;
      if (loadKey) begin
        loadSeen <= 1'b1;
        advCnt   <= '0;
      end else if (advance) begin
        advCnt   <= advCnt + 1'b1;
      end
    end
  end

  AST_CLEAR_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !loadSeen |-> subKey == '0); // R1

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!loadKey && !advance) |=> $stable(subKey)); // R6

  AST_RELOAD_REPEATS: assert property (@(posedge clk) disable iff (!rstN)
    (loadKey && $past(loadKey) && keyIn == $past(keyIn) &&
     decryptMode == $past(decryptMode)) |=> $stable(subKey)); // R2

  AST_CYCLE_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (loadSeen && !captureNext && advCnt == '0) |-> subKey == firstKey); // R7

endmodule

bind deskey_sched deskey_sched_chk uChk (.*);

// File: tb/tb_deskey_sched.sv
`timescale 1ns/1ps
module tb_deskey_sched;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] keyIn = '0;
  logic        loadKey = 1'b0;
  logic        advance = 1'b0;
  logic        decryptMode = 1'b0;
  logic [47:0] subKey;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [47:0] refKeys [16];
  int          refStep  = 0;
  bit          refDec   = 0;
  bit          refValid = 0;
  logic [47:0] expKey;

  int shiftsTab [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};
  int pc2Tab [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,23,19,12,4,26,8,16,7,27,20,13,2,
                      41,52,31,37,47,55,30,40,51,45,33,48,44,49,39,56,34,53,46,42,50,36,29,32};

  localparam logic [63:0] KEY_A  = 64'h133457799BBCDFF1;
  localparam logic [47:0] A_K1   = 48'h1B02EFFC7072;
  localparam logic [47:0] A_K16  = 48'hCB3D8B0E17F5;

  always #2.5 clk = ~clk;

  deskey_sched dut (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .loadKey(loadKey),
    .advance(advance), .decryptMode(decryptMode), .subKey(subKey)
  );

  function automatic int firstChoice(input int i);
    if (i < 28)      return 57 + i / 8 - 8 * (i % 8);
    else if (i < 52) return 63 - (i - 28) / 8 - 8 * ((i - 28) % 8);
    else             return 28 - 8 * (i - 52);
  endfunction

  task automatic expandKeys(input logic [63:0] k);
    logic [27:0] c, d;
    logic [55:0] cd;
    logic [47:0] sk;
    for (int i = 0; i < 28; i++) begin
      c[27 - i] = k[64 - firstChoice(i)];
      d[27 - i] = k[64 - firstChoice(i + 28)];
    end
    for (int r = 0; r < 16; r++) begin
      for (int s = 0; s < shiftsTab[r]; s++) begin
        c = {c[26:0], c[27]};
        d = {d[26:0], d[27]};
      end
      cd = {c, d};
      for (int j = 0; j < 48; j++) sk[47 - j] = cd[56 - pc2Tab[j]];
      refKeys[r] = sk;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic checkVal(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs, advance the model at the edge, compare mid-cycle.
  task automatic step(input string tag, input logic ld, input logic adv,
                      input logic dec, input logic [63:0] k);
    loadKey = ld; advance = adv; decryptMode = dec; keyIn = k;
    @(posedge clk);
    if (rstN) begin
      if (ld) begin
        expandKeys(k);
        refStep = 0; refDec = dec; refValid = 1;
      end else if (adv) begin
        refStep = (refStep + 1) % 16;
      end
    end
    #2;
    expKey = !refValid ? 48'h0 : (refDec ? refKeys[15 - refStep] : refKeys[refStep]);
    checkVal(tag, subKey, expKey);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    // R1: idle and advancing before any load stay zero
    step("R1", 0, 0, 0, 64'h0);
    step("R1", 0, 1, 0, KEY_A);
    step("R1", 0, 1, 1, KEY_A);

    // R2 / R11: load in encrypt mode gives K1 of the known key
    step("R2", 1, 0, 0, KEY_A);
    checkVal("R11", subKey, A_K1);
    step("R2", 1, 0, 0, KEY_A);
    // R3: forward order, with idle holds (R6) between some rounds
    for (int r = 1; r < 16; r++) begin
      step("R3", 0, 1, 0, 64'h0);
      if (r % 4 == 0) step("R6", 0, 0, 1, ~KEY_A);
    end
    checkVal("R3", subKey, A_K16);
    step("R7", 0, 1, 0, 64'h0);
    checkVal("R7", subKey, A_K1);

    // R4 / R5: decrypt order from K16 down to K1
    step("R4", 1, 0, 1, KEY_A);
    checkVal("R4", subKey, A_K16);
    for (int r = 1; r < 16; r++) step("R5", 0, 1, 1, 64'h0);
    checkVal("R5", subKey, A_K1);
    step("R7", 0, 1, 0, 64'h0);
    checkVal("R7", subKey, A_K16);

    // R8: load and advance together: load wins
    step("R8", 1, 1, 0, KEY_A);
    checkVal("R8", subKey, A_K1);
    step("R8", 1, 1, 1, KEY_A);
    checkVal("R8", subKey, A_K16);

    // R9: mode toggled without load does not change the order
    step("R9", 1, 0, 0, KEY_A);
    for (int r = 0; r < 6; r++) step("R9", 0, 1, r % 2, 64'h0);
    step("R9", 0, 0, 1, 64'h0);

    // R10: parity bits flipped give the same subkeys
    step("R10", 1, 0, 0, KEY_A ^ 64'h0101010101010101);
    checkVal("R10", subKey, A_K1);
    step("R10", 1, 0, 1, KEY_A ^ 64'h0101010101010101);
    checkVal("R10", subKey, A_K16);

    // weak keys: every subkey all zeros or all ones (R3 pattern)
    step("R3", 1, 0, 0, 64'h0101010101010101);
    for (int r = 0; r < 16; r++) begin
      step("R3", 0, 1, 0, 64'h0);
      checkVal("R3", subKey, 48'h0);
    end
    step("R5", 1, 0, 1, 64'hFEFEFEFEFEFEFEFE);
    for (int r = 0; r < 16; r++) begin
      step("R5", 0, 1, 1, 64'h0);
      checkVal("R5", subKey, {48{1'b1}});
    end

    // random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic ld, adv, dec;
      ld  = ($urandom % 12) == 0;
      adv = ($urandom % 2) == 0;
      dec = $urandom % 2;
      step(dec ? "R5" : "R3", ld, adv, dec, {$urandom, $urandom});
    end

    finishRun();
  end

endmodule